// File: doc/BRIEF.md
# XOR Phase Loss-of-Lock Detector

This block watches two slow square waves that a clock synthesizer has already divided down to a common comparison rate: one derived from the reference and one from the oscillator feedback. Both are brought into a fast sampling clock domain through two-stage synchronizers. The block then XORs them, so the fraction of time the XOR is high equals the phase error as a share of 180 degrees. A first-order digital leaky integrator smooths that level, and the result is compared against a threshold given in degrees.

The output flag is active low. It drops whenever the smoothed phase error rises above the threshold, and it rises once the two divided clocks agree closely enough. The filter time constant is 2^k sample cycles with k selectable. When the two inputs differ in frequency, k should be chosen so that the filter corner sits roughly ten times below the beat frequency. That keeps the smoothed level from sagging below the threshold during each beat. After reset the flag is held low for one full time constant so that the filter can settle before lock is reported.

Top module: `xor_lol_detector`

## Requirements
- R1: With both divided clocks at the same frequency and in phase, `lock_ok_n_o` is high (locked) once the post-reset hold has ended; a high value means locked and a low value means loss of lock.
- R2: While `rst_ni` is low and for 2^k sampling cycles after its release, `lock_ok_n_o` is low; it may go high no earlier than the following cycle.
- R3: The effective filter shift k is `flt_shift_i` clamped to the range 4..KMAX: a code below 4 acts as 4 and a code above KMAX acts as KMAX (KMAX is 20 by default).
- R4: The filter follows level += ((xor ? FS : 0) - level) >>> k with FS = 2^FS_W; the level never leaves 0..FS, never rises in a cycle whose XOR sample is 0, and never falls in a cycle whose XOR sample is 1.
- R5: A settled level corresponds to XOR duty × 180 degrees; the flag goes low exactly when the level strictly exceeds FS × code / 255.
- R6: The threshold code is 8 bits in units of 180/255 degrees; it is loaded from `thr_code_i` on a rising clock edge while `thr_load_i` is high, and reset sets it to 64 (about 45 degrees).
- R7: Code 0 with zero phase error reports lock (the comparison is strict), and code 255 reports lock even with a constant 180-degree error.
- R8: When the two divided clocks differ in frequency and the filter corner lies well below the beat rate, the flag stays low.
- R9: While `thr_load_i` is low, changes on `thr_code_i` have no effect on the held threshold or on the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| ref_div_i | input | 1 | Divided reference square wave (asynchronous) |
| fb_div_i | input | 1 | Divided oscillator feedback square wave (asynchronous) |
| thr_code_i | input | 8 | Phase threshold code, 180/255 degrees per step |
| thr_load_i | input | 1 | Captures `thr_code_i` into the threshold register |
| flt_shift_i | input | SHIFT_W (5) | Requested filter shift k, clamped to 4..KMAX |
| lock_ok_n_o | output | 1 | High when locked, low on loss of lock |

## Verification
The bench builds the block with FS_W = 20 and KMAX = 12. With these values the upper clamp of the shift is reached after only 4096 cycles of hold, and a beat-frequency run with a slow filter settles within the run time. The filter still keeps a resolution of 2^-8 of full scale at the largest shift, so the threshold comparisons remain sharp. Divided clocks with a 24-cycle period put phase errors on a 15-degree grid, which lets random threshold codes be judged against clear margins.

// File: rtl/lol_pkg.sv
// Shared constants for the XOR loss-of-lock detector.
// Assumes threshold codes span 0..255 over 0..180 degrees.
package lol_pkg;
    localparam int KMIN = 4;
    localparam int THR_W = 8;
    // Code nearest 45 degrees: round(45 * 255 / 180)
    localparam logic [THR_W-1:0] THR_DEFAULT = THR_W'((45 * 255 + 90) / 180);
endpackage

// File: rtl/lol_sync.sv
// Multi-stage synchronizer for one asynchronous bit.
// Assumes the input changes far slower than clk_i; STAGES >= 2.
module lol_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Stage 0 samples the raw input.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q[0] <= 1'b0;
        else         chain_q[0] <= d_i;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-samples the previous one.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) chain_q[s] <= 1'b0;
                else         chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lol_filter.sv
// First-order leaky integrator: level += ((x ? FS : 0) - level) >>> k.
// Assumes k_i <= FS_W; the level stays within 0..FS = 2^FS_W.
module lol_filter #(
    parameter int FS_W = 28,
    parameter int KW   = 5
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          x_i,
    input  logic [KW-1:0] k_i,
    output logic [FS_W:0] level_o
);
    localparam int LW = FS_W + 1;
    localparam int DW = FS_W + 2;
    localparam logic [LW-1:0] FS_VAL = LW'(1) << FS_W;

    logic [LW-1:0]        level_q;
    logic signed [DW-1:0] target;
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] step;
    logic [LW-1:0]        level_d;

    // Distance to the target scaled down by the shift.
    always_comb begin
        target  = x_i ? $signed({1'b0, FS_VAL}) : '0;
        diff    = target - $signed({1'b0, level_q});
        step    = diff >>> k_i;
        level_d = level_q + step[LW-1:0];
    end

    // Integrator state update.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) level_q <= '0;
        else         level_q <= level_d;
    end

    assign level_o = level_q;
endmodule

// File: rtl/lol_judge.sv
// Threshold register, post-reset hold counter and strict level compare.
// Assumes level_i <= 2^FS_W and k_i already clamped to KMIN..KMAX.
module lol_judge
    import lol_pkg::*;
#(
    parameter int FS_W = 28,
    parameter int KMAX = 20,
    parameter int KW   = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [FS_W:0]    level_i,
    input  logic [KW-1:0]    k_i,
    input  logic [THR_W-1:0] thr_code_i,
    input  logic             thr_load_i,
    output logic [THR_W-1:0] thr_q_o,
    output logic             lock_ok_n_o
);
    localparam int CW = KMAX + 1;
    localparam int PW = FS_W + THR_W + 1;

    logic [THR_W-1:0] thr_q;
    logic [CW-1:0]    hold_cnt;
    logic [CW-1:0]    hold_lim;
    logic             holding;
    logic [PW-1:0]    level_scaled;
    logic [PW-1:0]    thr_scaled;
    logic             over;
    logic             flag_q;

    // Threshold capture; reset picks the 45-degree code.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)         thr_q <= THR_DEFAULT;
        else if (thr_load_i) thr_q <= thr_code_i;
    end

    // Hold window length and state.
    always_comb begin
        hold_lim = CW'(1) << k_i;
        holding  = hold_cnt < hold_lim;
    end

    // Counts sample cycles since reset until the window closes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      hold_cnt <= '0;
        else if (holding) hold_cnt <= hold_cnt + 1'b1;
    end

    // level*255 against code*FS avoids a divide by 255.
    always_comb begin
        level_scaled = {level_i, {THR_W{1'b0}}} - PW'(level_i);
        thr_scaled   = {1'b0, thr_q, {FS_W{1'b0}}};
        over         = level_scaled > thr_scaled;
    end

    // Registered active-low lock flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= !(holding || over);
    end

    assign thr_q_o     = thr_q;
    assign lock_ok_n_o = flag_q;
endmodule

// File: rtl/xor_lol_detector.sv
// Top: synchronizes both divided clocks, XORs them, filters the XOR
// and reports lock against a degree threshold.
// Assumes both divided clocks are much slower than clk_i.
module xor_lol_detector
    import lol_pkg::*;
#(
    parameter int FS_W    = 28,
    parameter int KMAX    = 20,
    parameter int SHIFT_W = 5,
    parameter int SYNC_N  = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               ref_div_i,
    input  logic               fb_div_i,
    input  logic [THR_W-1:0]   thr_code_i,
    input  logic               thr_load_i,
    input  logic [SHIFT_W-1:0] flt_shift_i,
    output logic               lock_ok_n_o
);
    localparam int KW = $clog2(KMAX + 1);

    logic             ref_s;
    logic             fb_s;
    logic             phase_diff;
    logic [KW-1:0]    k_eff;
    logic [FS_W:0]    level_w;
    logic [THR_W-1:0] thr_cur;

    lol_sync #(.STAGES(SYNC_N)) u_sync_ref (
        .clk_i (clk_i), .rst_ni(rst_ni), .d_i(ref_div_i), .q_o(ref_s)
    );
    lol_sync #(.STAGES(SYNC_N)) u_sync_fb (
        .clk_i (clk_i), .rst_ni(rst_ni), .d_i(fb_div_i), .q_o(fb_s)
    );

    // Phase comparison and shift clamp.
    always_comb begin
        phase_diff = ref_s ^ fb_s;
        if (int'(flt_shift_i) < KMIN)      k_eff = KW'(KMIN);
        else if (int'(flt_shift_i) > KMAX) k_eff = KW'(KMAX);
        else                               k_eff = KW'(flt_shift_i);
    end

    lol_filter #(.FS_W(FS_W), .KW(KW)) u_filter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .x_i    (phase_diff),
        .k_i    (k_eff),
        .level_o(level_w)
    );

    lol_judge #(.FS_W(FS_W), .KMAX(KMAX), .KW(KW)) u_judge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .level_i    (level_w),
        .k_i        (k_eff),
        .thr_code_i (thr_code_i),
        .thr_load_i (thr_load_i),
        .thr_q_o    (thr_cur),
        .lock_ok_n_o(lock_ok_n_o)
    );
endmodule

// File: rtl/lol_checker.sv
// Property checker for xor_lol_detector, attached by bind below.
// Assumes the shift setting only changes while reset is asserted.
module lol_checker
    import lol_pkg::*;
#(
    parameter int FS_W = 28,
    parameter int KMAX = 20,
    parameter int KW   = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             lock_ok_n_o,
    input logic             phase_diff,
    input logic [KW-1:0]    k_eff,
    input logic [FS_W:0]    level_w,
    input logic [THR_W-1:0] thr_cur
);
    localparam int SW = KMAX + 2;
    localparam logic [FS_W:0] FS_VAL = (FS_W+1)'(1) << FS_W;

    logic [SW-1:0] since_q;
    logic [SW-1:0] window;

    // Saturating count of cycles since reset release.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)               since_q <= '0;
        else if (!since_q[SW-1])   since_q <= since_q + 1'b1;
    end

    assign window = SW'(1) << k_eff;

    // R2
    hold_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_q <= window) |-> !lock_ok_n_o);

    // R4
    level_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_w <= FS_VAL);

    // R4
    no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !phase_diff |=> level_w <= $past(level_w));

    // R4
    no_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_diff |=> level_w >= $past(level_w));

    // R6
    thr_default_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> thr_cur == THR_DEFAULT);
endmodule

bind xor_lol_detector lol_checker #(.FS_W(FS_W), .KMAX(KMAX), .KW(KW)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_ok_n_o(lock_ok_n_o),
    .phase_diff (phase_diff),
    .k_eff      (k_eff),
    .level_w    (level_w),
    .thr_cur    (thr_cur)
);

// File: tb/sim_xor_lol_detector.sv
module sim_xor_lol_detector;
    localparam int FS_W = 20;
    localparam int KMAX = 12;

    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       ref_div = 1'b0;
    logic       fb_div = 1'b0;
    logic [7:0] thr_code = 8'd0;
    logic       thr_load = 1'b0;
    logic [4:0] flt_shift = 5'd8;
    logic       lock_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int ref_per = 24, fb_per = 24;
    int ref_cnt = 0, fb_cnt = 0;

    always #2 clk = ~clk;

    xor_lol_detector #(.FS_W(FS_W), .KMAX(KMAX)) u0 (
        .clk_i(clk), .rst_ni(rst_ni), .ref_div_i(ref_div), .fb_div_i(fb_div),
        .thr_code_i(thr_code), .thr_load_i(thr_load), .flt_shift_i(flt_shift),
        .lock_ok_n_o(lock_n)
    );

    // Divided-clock generator, advanced between clock edges.
    always @(negedge clk) begin
        ref_cnt = (ref_cnt + 1) % ref_per;
        fb_cnt  = (fb_cnt + 1) % fb_per;
        ref_div = ref_cnt < ref_per / 2;
        fb_div  = fb_cnt < fb_per / 2;
    end

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (lock_n !== exp) begin
            n_bad++;
            $display("FAIL %s: lock_ok_n_o=%b expected %b at %0t", req, lock_n, exp, $time);
        end
    endtask

    // Feedback lags the reference by lag sample cycles.
    task automatic set_gen(input int rp, input int fp, input int lag);
        ref_per = rp;
        fb_per  = fp;
        ref_cnt = 0;
        fb_cnt  = (fp - (lag % fp)) % fp;
    endtask

    task automatic restart(input int rp, input int fp, input int lag, input int sh);
        rst_ni = 1'b0;
        set_gen(rp, fp, lag);
        flt_shift = 5'(sh);
        repeat (4) @(negedge clk);
        rst_ni = 1'b1;
    endtask

    task automatic load_thr(input int code);
        thr_code = 8'(code);
        thr_load = 1'b1;
        @(negedge clk);
        thr_load = 1'b0;
    endtask

    // Expected flag for a settled phase lag on a 24-cycle period.
    function automatic logic model_lock(input int lag, input int code);
        return (lag * 15 * 255) <= (code * 180);
    endfunction

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4711);
        // R2: flag low during reset
        repeat (3) @(negedge clk);
        check(1'b0, "R2");

        // R2 R1: hold window with k=8, clocks in phase
        restart(24, 24, 0, 8);
        repeat (256 - 10) @(negedge clk);
        check(1'b0, "R2");
        repeat (20) @(negedge clk);
        check(1'b1, "R1");

        // R3: shift code 0 clamps to 4 (16-cycle hold)
        restart(24, 24, 0, 0);
        repeat (10) @(negedge clk);
        check(1'b0, "R3");
        repeat (20) @(negedge clk);
        check(1'b1, "R3");

        // R3: shift code 31 clamps to KMAX=12 (4096-cycle hold)
        restart(24, 24, 0, 31);
        repeat (4096 - 10) @(negedge clk);
        check(1'b0, "R3");
        repeat (20) @(negedge clk);
        check(1'b1, "R3");

        // R6: default code 64 (~45 deg): 30 deg locks, 60 deg does not
        restart(24, 24, 2, 8);
        repeat (3000) @(negedge clk);
        check(1'b1, "R6");
        restart(24, 24, 4, 8);
        repeat (3000) @(negedge clk);
        check(1'b0, "R6");

        // R7: code 0 with no phase error, code 255 with 180-degree error
        restart(24, 24, 0, 8);
        load_thr(0);
        repeat (3000) @(negedge clk);
        check(1'b1, "R7");
        restart(24, 24, 12, 8);
        load_thr(255);
        repeat (3000) @(negedge clk);
        check(1'b1, "R7");

        // R9 R6: held code ignores input while load is low
        restart(24, 24, 6, 8);
        load_thr(170);
        repeat (3000) @(negedge clk);
        check(1'b1, "R6");
        thr_code = 8'd0;
        repeat (500) @(negedge clk);
        check(1'b1, "R9");
        load_thr(0);
        repeat (10) @(negedge clk);
        check(1'b0, "R6");

        // R4 R5: step from 0 to 180 deg against code 128 (~90 deg)
        restart(24, 24, 0, 8);
        load_thr(128);
        repeat (600) @(negedge clk);
        check(1'b1, "R4");
        set_gen(24, 24, 12);
        repeat (150) @(negedge clk);
        check(1'b1, "R4");
        repeat (70) @(negedge clk);
        check(1'b0, "R5");

        // R5: random codes and lags with clear margins
        for (int i = 0; i < 16; i++) begin
            int lag, code;
            do begin
                lag  = $urandom_range(0, 12);
                code = $urandom_range(0, 255);
            end while ((lag * 15 * 255 - code * 180) < 2040 &&
                       (code * 180 - lag * 15 * 255) < 2040);
            restart(24, 24, lag, 8);
            load_thr(code);
            repeat (3000) @(negedge clk);
            check(model_lock(lag, code), "R5");
        end

        // R8: 24 vs 26 cycle periods, k=12, code 43 (~30 deg)
        restart(24, 26, 0, 12);
        load_thr(43);
        repeat (25000) @(negedge clk);
        for (int j = 0; j < 4; j++) begin
            check(1'b0, "R8");
            repeat (157) @(negedge clk);
        end

        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule